// File: doc/BRIEF.md
# Revision Select and Protection Controller

This block sits between a programming port and a flash array divided into four equal design revisions. It decides which revision the configuration data streamer reads, and it guards programming-port traffic with per-revision security bits. The active revision comes either from two external select pins or from an internally held selection register. An external-select enable input chooses between the two sources. The pins and the enable are captured once, on the first clock edge after reset is released, and they are ignored after that.

Each revision has a read-protect bit and a write-protect (lock) bit. A read-protected revision returns zeros to port reads, and the attempt is recorded in a sticky violation flag. Read protection does not stop program or erase operations. A write-protected revision rejects program and erase. The only way to clear a read-protect bit is a successful erase of its revision. No command clears a write-protect bit; only reset does.

Port commands are a 3-bit opcode with a revision number, a word offset and write data. Array strobes are combinational from the command. Responses and reject pulses are registered one cycle later.

Top module: `revsel_guard`

## Requirements
- R1: If the external-select enable is high on the first rising clock edge after reset is released, the active revision becomes the 2-bit pin value sampled on that edge.
- R2: If the enable is low on that edge, the active revision follows the internal selection register. This register resets to revision 0, and opcode 6 (select) loads it with the command's revision from the next cycle on. In pin mode, opcode 6 still loads the register but leaves the active revision unchanged.
- R3: Changes on the select pins or on the enable after the capture edge do not change the active revision until the next reset.
- R4: The active base address output equals active revision × 2^OFFS_W. Port commands address revision × 2^OFFS_W + offset, and erase uses offset 0.
- R5: A read (opcode 0) of an unprotected revision asserts the array read strobe, and one cycle later it gives a response with the array data. A read of a read-protected revision asserts no strobe, responds with zero one cycle later, and sets the sticky violation flag.
- R6: The read-protect bit does not block program (opcode 1) or erase (opcode 2).
- R7: A successful erase clears the read-protect bit of that revision. Opcode 3 sets a read-protect bit, and opcode 4 sets a write-protect bit.
- R8: Program or erase of a write-protected revision asserts no array strobe and pulses the reject output one cycle later. A rejected erase changes none of that revision's bits.
- R9: The unlock opcode 5 clears no protect bit and has no other effect.
- R10: The status opcode 7 responds one cycle later with bit 8 = violation flag, bits 7:4 = write-protect bits, and bits 3:0 = read-protect bits (bit n is revision n).
- R11: Reset clears all protect bits, the violation flag, the response and reject outputs, and the selection register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_sel_en | input | 1 | Selects the pin source for the active revision (captured after reset) |
| rev_pins | input | 2 | External revision select pins |
| cmd_valid | input | 1 | Port command valid |
| cmd_op | input | 3 | Opcode: 0 read, 1 program, 2 erase, 3 set read-protect, 4 set write-protect, 5 unlock, 6 select, 7 status |
| cmd_rev | input | 2 | Target revision |
| cmd_offs | input | OFFS_W | Word offset within the revision |
| cmd_wdata | input | DATA_W | Program data |
| mem_rdata | input | DATA_W | Array read data (combinational) |
| mem_rd_en | output | 1 | Array read strobe |
| mem_wr_en | output | 1 | Array program strobe |
| mem_erase_en | output | 1 | Array revision erase strobe |
| mem_addr | output | OFFS_W+2 | Array address |
| mem_wdata | output | DATA_W | Array program data |
| rsp_valid | output | 1 | Response valid for read and status |
| rsp_data | output | DATA_W | Response data |
| cmd_reject | output | 1 | Pulse for a refused program or erase |
| active_rev | output | 2 | Active revision |
| active_base | output | OFFS_W+2 | Base address of the active revision |

## Verification
The bench targets the capture edge. A design that samples the pins continuously would move the active revision when the pins change after reset, and one that samples them late would miss the first value. It also checks the asymmetric gating: a design that let read protection block programming would drop a valid write strobe, and one that let read data through a protected revision would return array contents instead of zeros. The clearing paths are covered as well: a rejected erase on a locked revision must keep its read-protect bit, and an unlock opcode that cleared bits would show up in the next status word.

// File: rtl/revg_pkg.sv
package revg_pkg;
  localparam int REV_W   = 2;
  localparam int REV_CNT = 1 << REV_W;

  typedef enum logic [2:0] {
    OP_READ    = 3'd0,
    OP_PROG    = 3'd1,
    OP_ERASE   = 3'd2,
    OP_LOCK_RD = 3'd3,
    OP_LOCK_WR = 3'd4,
    OP_UNLOCK  = 3'd5,
    OP_SETSEL  = 3'd6,
    OP_STATUS  = 3'd7
  } op_e;

  // start word of a revision region
  function automatic logic [31:0] rev_base(input logic [REV_W-1:0] rev, input int offs_w);
    return 32'(rev) << offs_w;
  endfunction
endpackage

// File: rtl/revg_select.sv
module revg_select
  import revg_pkg::*;
#(
  parameter int DEFAULT_REV = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ext_sel_en,
  input  logic [REV_W-1:0] rev_pins,
  input  logic             set_en,
  input  logic [REV_W-1:0] set_rev,
  output logic [REV_W-1:0] active_rev,
  output logic             from_pins,
  output logic             armed
);
  logic [REV_W-1:0] pin_rev;
  logic [REV_W-1:0] sel_reg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed     <= 1'b0;
      from_pins <= 1'b0;
      pin_rev   <= '0;
      sel_reg   <= REV_W'(DEFAULT_REV);
    end else begin
      if (!armed) begin
        armed     <= 1'b1;
        from_pins <= ext_sel_en;
        pin_rev   <= rev_pins;
      end
      if (set_en) sel_reg <= set_rev;
    end
  end

  assign active_rev = from_pins ? pin_rev : sel_reg;
endmodule

// File: rtl/revg_prot.sv
module revg_prot
  import revg_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               set_rp,
  input  logic               set_wp,
  input  logic               erase_ok,
  input  logic [REV_W-1:0]   rev,
  output logic [REV_CNT-1:0] rp_bits,
  output logic [REV_CNT-1:0] wp_bits
);
  for (genvar g = 0; g < REV_CNT; g++) begin : g_bit
    logic hit;
    assign hit = (rev == REV_W'(g));

    always_ff @(posedge clk) begin
      if (!rst_n)               rp_bits[g] <= 1'b0;
      else if (erase_ok && hit) rp_bits[g] <= 1'b0;
      else if (set_rp && hit)   rp_bits[g] <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (!rst_n)             wp_bits[g] <= 1'b0;
      else if (set_wp && hit) wp_bits[g] <= 1'b1;
    end
  end
endmodule

// File: rtl/revsel_guard.sv
module revsel_guard
  import revg_pkg::*;
#(
  parameter int OFFS_W      = 8,
  parameter int DATA_W      = 16,
  parameter int DEFAULT_REV = 0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ext_sel_en,
  input  logic [1:0]            rev_pins,
  input  logic                  cmd_valid,
  input  logic [2:0]            cmd_op,
  input  logic [1:0]            cmd_rev,
  input  logic [OFFS_W-1:0]     cmd_offs,
  input  logic [DATA_W-1:0]     cmd_wdata,
  input  logic [DATA_W-1:0]     mem_rdata,
  output logic                  mem_rd_en,
  output logic                  mem_wr_en,
  output logic                  mem_erase_en,
  output logic [OFFS_W+1:0]     mem_addr,
  output logic [DATA_W-1:0]     mem_wdata,
  output logic                  rsp_valid,
  output logic [DATA_W-1:0]     rsp_data,
  output logic                  cmd_reject,
  output logic [1:0]            active_rev,
  output logic [OFFS_W+1:0]     active_base
);
  localparam int ADDR_W = OFFS_W + REV_W;
  localparam int STAT_W = 2 * REV_CNT + 1;

  op_e op;
  assign op = op_e'(cmd_op);

  logic [REV_CNT-1:0] rp_bits, wp_bits;
  logic               viol;
  logic               from_pins, armed;

  // named internal events
  logic rd_req, rd_ok, rd_block;
  logic pg_req, pg_block;
  logic er_req, er_ok, er_block;
  logic st_req, unlock_req;
  logic rp_hit, wp_hit;

  assign rp_hit     = rp_bits[cmd_rev];
  assign wp_hit     = wp_bits[cmd_rev];
  assign rd_req     = cmd_valid && (op == OP_READ);
  assign pg_req     = cmd_valid && (op == OP_PROG);
  assign er_req     = cmd_valid && (op == OP_ERASE);
  assign st_req     = cmd_valid && (op == OP_STATUS);
  assign unlock_req = cmd_valid && (op == OP_UNLOCK);
  assign rd_ok      = rd_req && !rp_hit;
  assign rd_block   = rd_req && rp_hit;
  assign pg_block   = pg_req && wp_hit;
  assign er_ok      = er_req && !wp_hit;
  assign er_block   = er_req && wp_hit;

  revg_select #(.DEFAULT_REV(DEFAULT_REV)) u_sel (
    .clk        (clk),
    .rst_n      (rst_n),
    .ext_sel_en (ext_sel_en),
    .rev_pins   (rev_pins),
    .set_en     (cmd_valid && (op == OP_SETSEL)),
    .set_rev    (cmd_rev),
    .active_rev (active_rev),
    .from_pins  (from_pins),
    .armed      (armed)
  );

  revg_prot u_prot (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_rp   (cmd_valid && (op == OP_LOCK_RD)),
    .set_wp   (cmd_valid && (op == OP_LOCK_WR)),
    .erase_ok (er_ok),
    .rev      (cmd_rev),
    .rp_bits  (rp_bits),
    .wp_bits  (wp_bits)
  );

  logic [ADDR_W-1:0] cmd_base;
  assign cmd_base     = ADDR_W'(rev_base(cmd_rev, OFFS_W));
  assign mem_addr     = er_req ? cmd_base : cmd_base + ADDR_W'(cmd_offs);
  assign mem_rd_en    = rd_ok;
  assign mem_wr_en    = pg_req && !wp_hit;
  assign mem_erase_en = er_ok;
  assign mem_wdata    = cmd_wdata;
  assign active_base  = ADDR_W'(rev_base(active_rev, OFFS_W));

  logic [STAT_W-1:0] status;
  assign status = {viol, wp_bits, rp_bits};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_data   <= '0;
      cmd_reject <= 1'b0;
      viol       <= 1'b0;
    end else begin
      rsp_valid  <= rd_req || st_req;
      rsp_data   <= rd_ok  ? mem_rdata :
                    st_req ? DATA_W'(status) : '0;
      cmd_reject <= pg_block || er_block;
      if (rd_block) viol <= 1'b1;
    end
  end
endmodule

// File: rtl/revg_chk.sv
module revg_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rd_block,
  input logic       pg_block,
  input logic       er_block,
  input logic       unlock_req,
  input logic       mem_rd_en,
  input logic       mem_wr_en,
  input logic       mem_erase_en,
  input logic [3:0] rp_bits,
  input logic [3:0] wp_bits,
  input logic       viol,
  input logic       from_pins,
  input logic       armed,
  input logic [1:0] active_rev
);
  // R5
  rd_gate_chk: assert property (@(posedge clk) disable iff (!rst_n) rd_block |-> !mem_rd_en);
  // R5
  viol_set_chk: assert property (@(posedge clk) disable iff (!rst_n) rd_block |=> viol);
  // R5
  viol_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n) viol |=> viol);
  // R8
  wr_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pg_block || er_block) |-> (!mem_wr_en && !mem_erase_en));
  // R8
  er_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    er_block |=> ($stable(rp_bits) && $stable(wp_bits)));
  // R9
  unlock_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unlock_req |=> ($stable(rp_bits) && $stable(wp_bits)));
  // R3
  pin_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && from_pins) |=> $stable(active_rev));
endmodule

bind revsel_guard revg_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .rd_block     (rd_block),
  .pg_block     (pg_block),
  .er_block     (er_block),
  .unlock_req   (unlock_req),
  .mem_rd_en    (mem_rd_en),
  .mem_wr_en    (mem_wr_en),
  .mem_erase_en (mem_erase_en),
  .rp_bits      (rp_bits),
  .wp_bits      (wp_bits),
  .viol         (viol),
  .from_pins    (from_pins),
  .armed        (armed),
  .active_rev   (active_rev)
);

// File: tb/tb_revsel_guard.sv
module tb_revsel_guard;
  localparam int OW = 8;
  localparam int DW = 16;

  logic clk = 0;
  always #10 clk = ~clk;

  logic rst_n, ext_sel_en, cmd_valid;
  logic [1:0] rev_pins, cmd_rev;
  logic [2:0] cmd_op;
  logic [OW-1:0] cmd_offs;
  logic [DW-1:0] cmd_wdata, mem_rdata, mem_wdata, rsp_data;
  logic mem_rd_en, mem_wr_en, mem_erase_en, rsp_valid, cmd_reject;
  logic [OW+1:0] mem_addr, active_base;
  logic [1:0] active_rev;

  function automatic logic [DW-1:0] arr_word(input int a);
    return DW'(a * 37 + 16'h5A17);
  endfunction
  assign mem_rdata = arr_word(int'(mem_addr));

  revsel_guard dut (.*);

  int n_run = 0, n_fail = 0;
  string cur_req = "R11";

  // reference state
  int m_rp[4], m_wp[4];
  int m_viol, m_sel, m_pins_mode, m_pin_rev;
  int e_rsp_v, e_rsp_d, e_rej;

  task automatic chk(string what, int act, int exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", cur_req, what, act, exp);
    end
  endtask

  function automatic int m_active();
    return m_pins_mode ? m_pin_rev : m_sel;
  endfunction

  task automatic check_regs();
    chk("rsp_valid", int'(rsp_valid), e_rsp_v);
    if (e_rsp_v != 0) chk("rsp_data", int'(rsp_data), e_rsp_d);
    chk("cmd_reject", int'(cmd_reject), e_rej);
    chk("active_rev", int'(active_rev), m_active());
    chk("active_base", int'(active_base), m_active() * (1 << OW));
  endtask

  task automatic do_reset(int ext, int pins);
    rst_n = 0; cmd_valid = 0; ext_sel_en = ext[0]; rev_pins = 2'(pins);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(posedge clk); @(negedge clk);
    foreach (m_rp[i]) begin m_rp[i] = 0; m_wp[i] = 0; end
    m_viol = 0; m_sel = 0; m_pins_mode = ext; m_pin_rev = pins;
    e_rsp_v = 0; e_rsp_d = 0; e_rej = 0;
    check_regs();
  endtask

  task automatic step(int op, int rev, int offs, int wd);
    int addr, rdok, rdblk, pgok, erok, blk, st;
    cmd_valid = 1; cmd_op = 3'(op); cmd_rev = 2'(rev);
    cmd_offs = OW'(offs); cmd_wdata = DW'(wd);
    #2;
    addr  = rev * (1 << OW) + ((op == 2) ? 0 : offs);
    rdok  = (op == 0 && m_rp[rev] == 0);
    rdblk = (op == 0 && m_rp[rev] != 0);
    pgok  = (op == 1 && m_wp[rev] == 0);
    erok  = (op == 2 && m_wp[rev] == 0);
    blk   = ((op == 1 || op == 2) && m_wp[rev] != 0);
    chk("mem_rd_en", int'(mem_rd_en), rdok);
    chk("mem_wr_en", int'(mem_wr_en), pgok);
    chk("mem_erase_en", int'(mem_erase_en), erok);
    if (rdok || pgok || erok) chk("mem_addr", int'(mem_addr), addr);
    if (pgok) chk("mem_wdata", int'(mem_wdata), wd & 16'hFFFF);
    st = m_viol * 256;
    for (int i = 0; i < 4; i++) st += m_wp[i] * (16 << i) + m_rp[i] * (1 << i);
    e_rsp_v = (op == 0 || op == 7);
    e_rsp_d = rdok ? int'(arr_word(addr)) : (op == 7) ? st : 0;
    e_rej = blk;
    if (rdblk) m_viol = 1;
    if (erok) m_rp[rev] = 0;
    if (op == 3) m_rp[rev] = 1;
    if (op == 4) m_wp[rev] = 1;
    if (op == 6) m_sel = rev;
    @(posedge clk); @(negedge clk);
    cmd_valid = 0;
    check_regs();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); @(negedge clk);
      e_rsp_v = 0; e_rej = 0;
      check_regs();
    end
  endtask

  bit done = 0;
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    cmd_op = 0; cmd_rev = 0; cmd_offs = 0; cmd_wdata = 0;
    @(negedge clk);
    // R1 R4 R11: pin mode capture
    cur_req = "R1"; do_reset(1, 2);
    cur_req = "R3"; rev_pins = 2'd1; ext_sel_en = 0; idle(4);
    cur_req = "R2"; step(6, 3, 0, 0); idle(1);
    cur_req = "R10"; step(7, 0, 0, 0);
    // R5 unprotected and protected reads
    cur_req = "R5"; step(0, 1, 5, 0); step(0, 3, 255, 0);
    cur_req = "R7"; step(3, 1, 0, 0);
    cur_req = "R5"; step(0, 1, 5, 0); step(7, 0, 0, 0);
    cur_req = "R6"; step(1, 1, 9, 16'hBEEF);
    cur_req = "R9"; step(5, 1, 0, 0); step(7, 0, 0, 0);
    cur_req = "R7"; step(2, 1, 77, 0); step(0, 1, 5, 0); step(7, 0, 0, 0);
    // R8 write lock
    cur_req = "R8"; step(3, 3, 0, 0); step(4, 3, 0, 0);
    step(1, 3, 4, 16'h1234); step(2, 3, 0, 0); step(7, 0, 0, 0);
    cur_req = "R9"; step(5, 3, 0, 0); step(7, 0, 0, 0);
    cur_req = "R6"; step(1, 0, 3, 16'h0F0F); step(2, 2, 0, 0);
    // R2 internal mode
    cur_req = "R11"; do_reset(0, 3); step(7, 0, 0, 0);
    cur_req = "R2"; step(6, 2, 0, 0); idle(1);
    cur_req = "R3"; rev_pins = 2'd1; ext_sel_en = 1; idle(3);
    cur_req = "R4"; step(6, 3, 0, 0); step(0, 2, 17, 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule